// File: doc/BRIEF.md
# Hidden-Bit Float Adder/Subtractor

This block adds or subtracts two 64-bit floating register images in the legacy hidden-bit format and rounds the result to either the short (single) or the long (double) precision. Each register image holds a sign in bit 63, an 11-bit excess-1024 exponent in bits 62:52 and a 52-bit fraction in bits 51:0 with an implied leading one. A zero exponent with an all-zero word is true zero. A zero exponent with any other bit set is a reserved operand. A caller presents both operands with the operation controls and pulses `start`. The packed result and its three flags come back three cycles later with `res_valid`. A new operation may enter every cycle.

The datapath has three registered stages. The alignment stage unpacks both operands, checks for reserved operands, inverts the second sign for subtraction and orders the operands by magnitude. It then right-aligns the smaller fraction and picks one of three paths: `PATH_RSV` for a reserved operand, `PATH_ADD` when the signs agree or an operand is zero, and `PATH_SUB` when the signs differ. The add/normalize stage dispatches on that path. `PATH_ADD` takes the 64-bit sum and absorbs a carry with a one-place right shift. `PATH_SUB` takes the difference, which is never negative, and normalizes it with a leading-zero count. `PATH_RSV` forces a zero word. The last stage rounds or chops at the selected precision, then clamps an overflow or flushes an underflow, and packs the result. Every path flows straight through. There is no looping state.

Top module: `hbf_addsub`

## Requirements
- R1: `res_valid` is high exactly three clock edges after an edge that sampled `start` high. One result leaves per cycle, in issue order. After reset `res_valid` and `result` are zero.
- R2: If either operand has a zero exponent field (bits 62:52) and is not all zeros, `result` is zero and `flag_invalid` is set. `flag_invalid` is clear for all other operands.
- R3: With `do_sub` high, the sign (bit 63) of `opnd_b` is inverted before any other step, so zero minus y returns y with its sign flipped.
- R4: A zero first operand yields the second operand (with the R3 sign), rounded. A zero second operand yields the first, rounded. Two zeros yield +0.
- R5: The operand of larger magnitude sets the result sign. Magnitude is the exponent, then the fraction. Equal magnitudes with opposite effective signs give exactly +0 with no flag.
- R6: On effective subtraction, the smaller fraction is right-shifted by the exponent gap and any lost nonzero bits are ORed into its lowest bit. A gap above 63 reduces it to just that sticky 1. The difference is then normalized so its leading one is at the top.
- R7: On effective addition, a gap above 63 drops the smaller operand entirely, with no sticky bit. Otherwise the smaller operand is right-shifted, truncated and added.
- R8: A carry out of the 64-bit fraction sum shifts the sum right one place with a forced leading one and raises the exponent by one.
- R9: With `round_en` high, half a unit in the last kept place is added before truncation. That is bit 10 of the 64-bit internal fraction (leading one at bit 63) for long precision and bit 39 for short. A carry from it renormalizes and raises the exponent. With `round_en` low the result is chopped.
- R10: With `to_single` high, only the top 23 fraction bits are kept, so result bits 28:0 are zero.
- R11: An exponent above 2047 (long) or 1151 (short) sets `flag_overflow` and clamps the exponent field to that maximum, keeping the fraction.
- R12: An exponent at or below 0 (long) or 896 (short) gives a zero result. `flag_underflow` is set only when `trap_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept an operation this cycle |
| opnd_a | input | 64 | First operand register image |
| opnd_b | input | 64 | Second operand register image |
| do_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| to_single | input | 1 | 1 = short-precision result, 0 = long |
| round_en | input | 1 | 1 = round half up, 0 = chop |
| trap_en | input | 1 | Enables the underflow flag |
| res_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Packed result register image |
| flag_invalid | output | 1 | Reserved operand seen |
| flag_overflow | output | 1 | Exponent clamped to maximum |
| flag_underflow | output | 1 | Result flushed to zero with trap enabled |

## Verification
Exact cancellation (x minus x) and near cancellation (x minus its lower neighbour) drive `PATH_SUB` through its deepest normalization shift and separate a wrong swap or sign rule from a correct one. Exponent gaps of more than 63 are applied with equal and with opposite signs. They show whether the sticky bit is kept only on subtraction, and a rounded run on the same inputs shows the sticky bit reaching the round stage. Equal operands with the fraction saturated force the carry-out path. Operands at the exponent limits of both precisions, with the trap enable on and off, separate the overflow clamp from the underflow flush. Seeded random operands, biased toward equal and nearby exponents and mixed with zeros and reserved words, are issued back to back and with gaps. They are compared with a bench model and check the pipeline ordering.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    localparam int WORD      = 64;
    localparam int EXPW      = 11;
    localparam int FRW       = 52;
    localparam int GUARD     = WORD - 1 - FRW;
    localparam int XW        = EXPW + 3;
    localparam int SHW       = $clog2(WORD);
    localparam int LZW       = SHW + 1;
    localparam int G_BIAS    = 1 << (EXPW - 1);
    localparam int F_EXPW    = 8;
    localparam int F_FRW     = 23;
    localparam int F_BIAS    = 1 << (F_EXPW - 1);
    localparam int G_EMAX    = (1 << EXPW) - 1;
    localparam int G_EMIN    = 0;
    localparam int F_EMAX    = G_BIAS - F_BIAS + (1 << F_EXPW) - 1;
    localparam int F_EMIN    = G_BIAS - F_BIAS;
    localparam int G_RND_POS = GUARD - 1;
    localparam int F_RND_POS = WORD - 2 - F_FRW;
    localparam int F_CLR     = FRW - F_FRW;

    typedef enum logic [1:0] {
        PATH_RSV = 2'd0,
        PATH_ADD = 2'd1,
        PATH_SUB = 2'd2
    } path_e;

    typedef struct packed {
        logic                   vld;
        path_e                  path;
        logic                   sgn;
        logic signed [XW-1:0]   exp;
        logic [WORD-1:0]        fa;
        logic [WORD-1:0]        fb;
        logic                   fprec;
        logic                   rnd;
        logic                   trap;
    } align_t;

    typedef struct packed {
        logic                   vld;
        logic                   inv;
        logic                   sgn;
        logic signed [XW-1:0]   exp;
        logic [WORD-1:0]        frac;
        logic                   fprec;
        logic                   rnd;
        logic                   trap;
    } norm_t;
endpackage

// File: rtl/hbf_align.sv
module hbf_align
    import hbf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WORD-1:0] opa,
    input  logic [WORD-1:0] opb,
    input  logic            sub,
    input  logic            fprec,
    input  logic            rnd,
    input  logic            trap,
    output align_t          q
);
    logic [EXPW-1:0]     ea, eb, el, es, dlt;
    logic [WORD-1:0]     ma, mb, ml, ms;
    logic                sa, sb, sl, ss, swap, rsv;
    logic [2*WORD-1:0]   wide;
    logic [SHW-1:0]      d6;
    align_t              nxt;

    always_comb begin
        ea   = opa[WORD-2 -: EXPW];
        eb   = opb[WORD-2 -: EXPW];
        sa   = opa[WORD-1];
        sb   = opb[WORD-1] ^ sub;
        ma   = {1'b1, opa[FRW-1:0], {GUARD{1'b0}}};
        mb   = {1'b1, opb[FRW-1:0], {GUARD{1'b0}}};
        rsv  = ((ea == '0) && (opa != '0)) || ((eb == '0) && (opb != '0));
        swap = (ea < eb) || ((ea == eb) && (ma < mb));
        el   = swap ? eb : ea;
        es   = swap ? ea : eb;
        ml   = swap ? mb : ma;
        ms   = swap ? ma : mb;
        sl   = swap ? sb : sa;
        ss   = swap ? sa : sb;
        dlt  = el - es;
        d6   = dlt[SHW-1:0];
        wide = {ms, {WORD{1'b0}}} >> d6;

        nxt       = '0;
        nxt.vld   = start;
        nxt.fprec = fprec;
        nxt.rnd   = rnd;
        nxt.trap  = trap;
        if (rsv) begin
            nxt.path = PATH_RSV;
        end else if (ea == '0) begin
            nxt.path = PATH_ADD;
            nxt.sgn  = (eb == '0) ? 1'b0 : sb;
            nxt.exp  = {{(XW-EXPW){1'b0}}, eb};
            nxt.fa   = (eb == '0) ? '0 : mb;
        end else if (eb == '0) begin
            nxt.path = PATH_ADD;
            nxt.sgn  = sa;
            nxt.exp  = {{(XW-EXPW){1'b0}}, ea};
            nxt.fa   = ma;
        end else begin
            nxt.sgn = sl;
            nxt.exp = {{(XW-EXPW){1'b0}}, el};
            nxt.fa  = ml;
            if (sl ^ ss) begin
                nxt.path = PATH_SUB;
                if (dlt > EXPW'(WORD - 1))
                    nxt.fb = {{(WORD-1){1'b0}}, 1'b1};
                else
                    nxt.fb = wide[2*WORD-1:WORD] | {{(WORD-1){1'b0}}, |wide[WORD-1:0]};
            end else begin
                nxt.path = PATH_ADD;
                nxt.fb   = (dlt > EXPW'(WORD - 1)) ? '0 : wide[2*WORD-1:WORD];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/hbf_addnorm.sv
module hbf_addnorm
    import hbf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  align_t a,
    output norm_t  q
);
    function automatic logic [LZW-1:0] lead_zeros(input logic [WORD-1:0] v);
        logic [LZW-1:0] n;
        logic           hit;
        n   = '0;
        hit = 1'b0;
        for (int i = WORD - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

    logic [WORD:0]    sum;
    logic [WORD-1:0]  dif;
    logic [LZW-1:0]   lz;
    norm_t            nxt;

    always_comb begin
        sum       = {1'b0, a.fa} + {1'b0, a.fb};
        dif       = a.fa - a.fb;
        lz        = lead_zeros(dif);
        nxt       = '0;
        nxt.vld   = a.vld;
        nxt.fprec = a.fprec;
        nxt.rnd   = a.rnd;
        nxt.trap  = a.trap;
        unique case (a.path)
            PATH_RSV: begin
                nxt.inv = 1'b1;
            end
            PATH_ADD: begin
                nxt.sgn = a.sgn;
                if (sum[WORD]) begin
                    nxt.frac = sum[WORD:1];
                    nxt.exp  = a.exp + XW'(1);
                end else begin
                    nxt.frac = sum[WORD-1:0];
                    nxt.exp  = a.exp;
                end
            end
            PATH_SUB: begin
                if (dif != '0) begin
                    nxt.sgn  = a.sgn;
                    nxt.frac = dif << lz;
                    nxt.exp  = a.exp - $signed({{(XW-LZW){1'b0}}, lz});
                end
            end
            default: nxt.inv = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R5: the swap leaves the larger fraction on top for subtraction
    p_sub_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a.vld && a.path == PATH_SUB) |-> (a.fa >= a.fb));

    // R6: normalized output has its leading one at the top
    p_norm_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && q.frac != '0) |-> q.frac[WORD-1]);
endmodule

// File: rtl/hbf_round_pack.sv
module hbf_round_pack
    import hbf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  norm_t           n,
    output logic            vld_o,
    output logic [WORD-1:0] res_o,
    output logic            inv_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam logic [EXPW-1:0] G_EMAX_FLD = EXPW'(G_EMAX);
    localparam logic [EXPW-1:0] F_EMAX_FLD = EXPW'(F_EMAX);

    logic [WORD-1:0]      rbit, m;
    logic [WORD:0]        sum;
    logic signed [XW-1:0] e, emax, emin;
    logic [FRW-1:0]       fr;
    logic [WORD-1:0]      res;
    logic                 ovf, unf, fprec_q;

    always_comb begin
        rbit = n.fprec ? (WORD'(1) << F_RND_POS) : (WORD'(1) << G_RND_POS);
        emax = n.fprec ? XW'(F_EMAX) : XW'(G_EMAX);
        emin = n.fprec ? XW'(F_EMIN) : XW'(G_EMIN);
        sum  = {1'b0, n.frac} + {1'b0, (n.rnd ? rbit : '0)};
        m    = sum[WORD] ? sum[WORD:1] : sum[WORD-1:0];
        e    = n.exp + (sum[WORD] ? XW'(1) : XW'(0));
        fr   = m[WORD-2:GUARD];
        if (n.fprec) fr[F_CLR-1:0] = '0;
        ovf  = 1'b0;
        unf  = 1'b0;
        res  = '0;
        if (n.frac != '0) begin
            if (e > emax) begin
                ovf = 1'b1;
                e   = emax;
            end
            if (e <= emin) unf = n.trap;
            else           res = {n.sgn, e[EXPW-1:0], fr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            res_o   <= '0;
            inv_o   <= 1'b0;
            ovf_o   <= 1'b0;
            unf_o   <= 1'b0;
            fprec_q <= 1'b0;
        end else begin
            vld_o   <= n.vld;
            res_o   <= res;
            inv_o   <= n.inv;
            ovf_o   <= ovf;
            unf_o   <= unf;
            fprec_q <= n.fprec;
        end
    end

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && inv_o) |-> (res_o == '0));

    p_unf_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && unf_o) |-> (res_o == '0));

    p_ovf_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && ovf_o) |->
        (res_o[WORD-2 -: EXPW] == (fprec_q ? F_EMAX_FLD : G_EMAX_FLD)));

    p_fshort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && fprec_q) |-> (res_o[F_CLR-1:0] == '0));
endmodule

// File: rtl/hbf_addsub.sv
module hbf_addsub
    import hbf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WORD-1:0] opnd_a,
    input  logic [WORD-1:0] opnd_b,
    input  logic            do_sub,
    input  logic            to_single,
    input  logic            round_en,
    input  logic            trap_en,
    output logic            res_valid,
    output logic [WORD-1:0] result,
    output logic            flag_invalid,
    output logic            flag_overflow,
    output logic            flag_underflow
);
    align_t s1;
    norm_t  s2;

    hbf_align u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .opa   (opnd_a),
        .opb   (opnd_b),
        .sub   (do_sub),
        .fprec (to_single),
        .rnd   (round_en),
        .trap  (trap_en),
        .q     (s1)
    );

    hbf_addnorm u_addnorm (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (s1),
        .q     (s2)
    );

    hbf_round_pack u_round (
        .clk   (clk),
        .rst_n (rst_n),
        .n     (s2),
        .vld_o (res_valid),
        .res_o (result),
        .inv_o (flag_invalid),
        .ovf_o (flag_overflow),
        .unf_o (flag_underflow)
    );

    p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> s1.vld);

    p_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s2.vld |=> res_valid);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s2.vld |=> !res_valid);
endmodule

// File: tb/test_hbf_addsub.sv
module test_hbf_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        do_sub = 1'b0, to_single = 1'b0, round_en = 1'b0, trap_en = 1'b0;
    logic        res_valid, flag_invalid, flag_overflow, flag_underflow;
    logic [63:0] result;

    always #2 clk = ~clk;

    hbf_addsub i_hbf_addsub (
        .clk(clk), .rst_n(rst_n), .start(start), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .do_sub(do_sub), .to_single(to_single), .round_en(round_en), .trap_en(trap_en),
        .res_valid(res_valid), .result(result), .flag_invalid(flag_invalid),
        .flag_overflow(flag_overflow), .flag_underflow(flag_underflow)
    );

    typedef struct {
        logic [63:0] r;
        logic        i, o, u;
        string       tag;
    } exp_t;

    exp_t  q_exp[$];
    exp_t  cur;
    int    checks = 0, fails = 0, cyc = 0;
    logic  done = 1'b0;
    logic [2:0] hist = '0;

    // Bench model built from R2..R12
    function automatic void ref_op(input logic [63:0] x, input logic [63:0] y,
                                   input logic sub, input logic fp, input logic rn,
                                   input logic tr, output logic [63:0] r,
                                   output logic inv, output logic ov, output logic un);
        int          ex, ey, e, d, emax, emin;
        logic        sx, sy, s, sl, ss;
        logic [63:0] mx, my, ml, msm, m;
        logic [64:0] t;
        logic [127:0] w;
        logic [51:0] f;
        r = '0; inv = 0; ov = 0; un = 0;
        ex = int'(x[62:52]); ey = int'(y[62:52]);
        if ((ex == 0 && x != 0) || (ey == 0 && y != 0)) begin inv = 1; return; end
        sx = x[63]; sy = y[63] ^ sub;
        mx = {1'b1, x[51:0], 11'b0}; my = {1'b1, y[51:0], 11'b0};
        if (ex == 0 && ey == 0) return;
        if (ex == 0) begin s = sy; e = ey; m = my; end
        else if (ey == 0) begin s = sx; e = ex; m = mx; end
        else begin
            if (ex < ey || (ex == ey && mx < my)) begin
                e = ey; ml = my; sl = sy; d = ey - ex; msm = mx; ss = sx;
            end else begin
                e = ex; ml = mx; sl = sx; d = ex - ey; msm = my; ss = sy;
            end
            s = sl;
            if (sl != ss) begin
                if (d > 63) msm = 64'd1;
                else begin
                    w = {msm, 64'd0} >> d;
                    msm = w[127:64] | {63'd0, |w[63:0]};
                end
                m = ml - msm;
                if (m == 0) return;
                while (!m[63]) begin m = m << 1; e = e - 1; end
            end else begin
                if (d > 63) msm = 0; else msm = msm >> d;
                t = {1'b0, ml} + {1'b0, msm};
                if (t[64]) begin m = t[64:1]; e = e + 1; end
                else m = t[63:0];
            end
        end
        t = {1'b0, m} + (rn ? (fp ? 65'h80_0000_0000 : 65'h400) : 65'd0);
        if (t[64]) begin m = t[64:1]; e = e + 1; end else m = t[63:0];
        emax = fp ? 1151 : 2047;
        emin = fp ? 896 : 0;
        if (e > emax) begin ov = 1; e = emax; end
        if (e <= emin) begin un = tr; return; end
        f = m[62:11];
        if (fp) f[28:0] = '0;
        r = {s, e[10:0], f};
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic sb,
                         input logic fp, input logic rn, input logic tr, input string tag);
        exp_t it;
        @(negedge clk);
        opnd_a = a; opnd_b = b; do_sub = sb; to_single = fp; round_en = rn; trap_en = tr;
        start = 1'b1;
        ref_op(a, b, sb, fp, rn, tr, it.r, it.i, it.o, it.u);
        it.tag = tag;
        q_exp.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    function automatic logic [63:0] rand_op(input logic [10:0] base);
        int          kind;
        logic [10:0] e;
        logic [51:0] f;
        kind = int'($urandom % 16);
        f = {$urandom, $urandom};
        e = 11'($urandom);
        if (kind == 0) return 64'd0;
        if (kind == 1) return {1'($urandom), 11'd0, 52'd1 | f};
        if (kind < 6) e = base;
        else if (kind < 9) e = base + 11'($urandom % 5) - 11'd2;
        if (e == 0) e = 11'd1;
        return {1'($urandom), e, f};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[1:0], start};
    end

    // R1: valid three edges after issue, results in issue order
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (hist[2] || res_valid) begin
                checks++;
                if (hist[2] !== res_valid) begin
                    fails++;
                    $display("FAIL R1: res_valid %b expected %b", res_valid, hist[2]);
                end
            end
            if (res_valid) begin
                if (q_exp.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1: unexpected result %h expected none", result);
                end else begin
                    cur = q_exp.pop_front();
                    checks++;
                    if (result !== cur.r || flag_invalid !== cur.i ||
                        flag_overflow !== cur.o || flag_underflow !== cur.u) begin
                        fails++;
                        $display("FAIL %s: got %h inv%b ovf%b unf%b expected %h inv%b ovf%b unf%b",
                                 cur.tag, result, flag_invalid, flag_overflow, flag_underflow,
                                 cur.r, cur.i, cur.o, cur.u);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R1: watchdog expired at cycle %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    localparam logic [63:0] X1 = {1'b0, 11'h400, 52'h0};
    localparam logic [63:0] ND = {1'b0, 11'h3FF, 52'hF_FFFF_FFFF_FFFF};
    localparam logic [63:0] Y  = {1'b0, 11'h500, 52'hA_BCDE_F012_3456};
    localparam logic [63:0] BIG = {1'b0, 11'h600, 52'h1_2345};

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || result !== 64'd0) begin
            fails++;
            $display("FAIL R1: reset state valid %b result %h expected 0 0", res_valid, result);
        end
        rst_n = 1'b1;
        idle(2);
        // R5 exact cancellation, both orders of near cancellation
        issue(X1, X1, 1, 0, 1, 0, "R5");
        issue(X1, ND, 1, 0, 0, 0, "R6");
        issue(X1, ND, 1, 0, 1, 0, "R6");
        issue(ND, X1, 1, 0, 0, 0, "R5");
        issue({1'b1, X1[62:0]}, X1, 0, 0, 0, 0, "R5");
        // R2 reserved operands
        issue({1'b1, 63'd0}, X1, 0, 0, 1, 0, "R2");
        issue(X1, {12'd0, 52'd1}, 1, 1, 0, 1, "R2");
        // R3 / R4 zero handling
        issue(64'd0, Y, 1, 0, 0, 0, "R3");
        issue(64'd0, Y, 0, 0, 1, 0, "R4");
        issue(Y, 64'd0, 1, 0, 0, 0, "R4");
        issue(64'd0, 64'd0, 1, 0, 0, 0, "R4");
        issue(64'd0, {1'b1, 63'd0}, 0, 0, 0, 0, "R2");
        idle(1);
        // R7 / R6 large gaps
        issue(BIG, X1, 0, 0, 1, 0, "R7");
        issue(BIG, X1, 1, 0, 0, 0, "R6");
        issue(BIG, X1, 1, 0, 1, 0, "R9");
        issue(X1, BIG, 1, 0, 0, 0, "R6");
        // R8 carry out
        issue(Y, Y, 0, 0, 0, 0, "R8");
        issue({1'b1, 11'h200, 52'hF_FFFF_FFFF_FFFF}, {1'b1, 11'h200, 52'hF_FFFF_FFFF_FFFF}, 0, 0, 1, 0, "R8");
        // R9 rounding with guard bits
        issue({1'b0, 11'h400, 52'hF_FFFF_FFFF_FFFF}, {1'b0, 11'h3CB, 52'h8_0000_0000_0000}, 0, 0, 1, 0, "R9");
        issue({1'b0, 11'h400, 52'hF_FFFF_FFFF_FFFF}, {1'b0, 11'h3CB, 52'h8_0000_0000_0000}, 0, 0, 0, 0, "R9");
        // R10 short precision
        issue({1'b0, 11'h420, 52'hF_FFFF_F000_0000}, 64'd0, 0, 1, 1, 0, "R10");
        issue({1'b0, 11'h420, 52'hF_FFFF_F000_0000}, 64'd0, 0, 1, 0, 0, "R10");
        issue(Y, X1, 1, 1, 1, 0, "R10");
        // R11 overflow, both precisions
        issue({1'b0, 11'h7FF, 52'd1}, {1'b0, 11'h7FF, 52'd1}, 0, 0, 0, 0, "R11");
        issue({1'b1, 11'd1151, 52'd5}, {1'b1, 11'd1151, 52'd5}, 0, 1, 0, 0, "R11");
        issue(Y, 64'd0, 0, 1, 1, 0, "R11");
        // R12 underflow, both precisions, trap off and on
        issue({1'b0, 11'd1, 52'd1}, {1'b0, 11'd1, 52'd0}, 1, 0, 0, 0, "R12");
        issue({1'b0, 11'd1, 52'd1}, {1'b0, 11'd1, 52'd0}, 1, 0, 0, 1, "R12");
        issue({1'b0, 11'd896, 52'd7}, 64'd0, 0, 1, 0, 1, "R12");
        issue({1'b0, 11'd897, 52'd3}, {1'b0, 11'd897, 52'd0}, 1, 1, 1, 0, "R12");
        issue({1'b0, 11'd897, 52'd3}, {1'b0, 11'd897, 52'd0}, 1, 1, 1, 1, "R12");
        idle(4);
        // Random stream, back to back and with gaps
        for (int n = 0; n < 600; n++) begin
            logic [10:0] base;
            base = 11'($urandom);
            if (($urandom % 4) == 0) idle(1);
            issue(rand_op(base), rand_op(base), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), "R1");
        end
        idle(6);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results missing expected 0", q_exp.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule